// File: doc/BRIEF.md
# Windowed watchdog timer

This block is a down-counting watchdog that the rest of the chip must service. The counter runs only while enabled and steps once every four clocks. Software restarts it by writing a two-byte key sequence into a feed register. When the count reaches a programmed warning level, the block raises a level interrupt. In reset mode, the block emits a one-cycle reset request in any of these cases:

- the count runs out;
- the key sequence is broken;
- a feed lands while the count is still above the window level;
- software tries to change the reload value while the reload value is locked.

The control bits can only be set. The only ways to clear them are the external reset and the watchdog's own reset. After a watchdog reset, a cause bit stays set so that software can tell why the chip restarted. Registers are reached through a synchronous write strobe with an address and data. Reads are combinational from the address.

Top module: `wdt_window_top`

## Requirements
- R1: After `rst_ni` is released, the registers read as follows: control (address 0) = 0, reload (address 1) = 0xFF, count (address 3) = 0xFF, warning (address 4) = 0, window (address 5) = 0xFFFFFF. Both `irq_o` and `rst_req_o` are low.
- R2: The control register has these fields: bit 0 enable, bit 1 reset mode, bit 2 timeout flag, bit 3 warning flag, bit 4 reload lock, bit 5 watchdog-reset cause. Writing 0 to bit 0, bit 1 or bit 4 leaves a set bit set.
- R3: The timeout flag (bit 2) is set when the running count steps past zero or when a feed sequence is broken. A control write with bit 2 = 0 clears it. A control write with bit 2 = 1 leaves it unchanged.
- R4: When a running count steps onto the warning value, the warning flag (bit 3) and `irq_o` go high. A control write with bit 3 = 1 clears both.
- R5: A reload write of a value below 0xFF stores 0xFF. Any other value is stored unchanged.
- R6: While enabled, the count drops by one every 4 clocks, and a feed restarts the 4-clock phase.
- R7: With the enable bit set and reset mode clear, a timeout reloads the count and never asserts `rst_req_o`.
- R8: A feed is a write of 0xAA to the feed register (address 2) followed immediately by a write of 0x55 to it. A feed loads the count from the reload register. Any other write that follows 0xAA breaks the sequence.
- R9: In reset mode, a feed that completes while the count is above the window value requests a reset. A feed that completes with the count at or below the window value does not.
- R10: With the lock bit set, a reload write requests a reset unless the count is below both the warning value and the window value. When the count is below both, the write is accepted.
- R11: Every reset request is a single-cycle `rst_req_o` pulse. The timeout case applies only in reset mode. After the pulse, every register is back at its R1 value, except that control bit 5 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous external reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 24 | Write data |
| reg_rdata_o | output | 24 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Warning interrupt, follows the warning flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The hardest state to reach from the ports is a locked reload write that is legal. It needs the count to have fallen below both the warning value and the window value. After a watchdog reset, however, the warning value is back at 0, so no count can be below it. The stimulus therefore first provokes a protect fault. It then re-enables the block with the lock bit set, raises the warning and window values, and idles for a counted number of clocks until the count is below both. Only then does it write the reload value. The window test reaches a legal feed in a similar way: it lets the count fall from 0xFF past the window level for a known number of clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_FEED   = 3'd2,
    A_COUNT  = 3'd3,
    A_WARN   = 3'd4,
    A_WINDOW = 3'd5
  } wdt_addr_e;

  localparam int B_EN    = 0;
  localparam int B_RSTEN = 1;
  localparam int B_TOF   = 2;
  localparam int B_WARN  = 3;
  localparam int B_LOCK  = 4;
  localparam int B_CAUSE = 5;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  assign tick_o = run_i && (ph_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (run_i)  ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       we_i,
  input  logic       is_feed_i,
  input  logic [7:0] data_i,
  output logic       feed_ok_o,
  output logic       feed_err_o
);
  logic armed_q;
  logic second_hit, first_hit;

  assign first_hit  = we_i && is_feed_i && (data_i == KEY_FIRST);
  assign second_hit = we_i && is_feed_i && (data_i == KEY_SECOND);
  assign feed_ok_o  = armed_q && second_hit;
  assign feed_err_o = armed_q && we_i && !second_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (clr_i) armed_q <= 1'b0;
    else if (we_i)  armed_q <= !armed_q && first_hit;
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int              W       = 24,
  parameter logic [W-1:0]    RST_VAL = 'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= RST_VAL;
    else if (clr_i)                  cnt_o <= RST_VAL;
    else if (load_i)                 cnt_o <= load_val_i;
    else if (tick_i && cnt_o != '0)  cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int DIV        = 4,
  parameter int MIN_RELOAD = 'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] RLD_MIN = CNT_W'(MIN_RELOAD);
  localparam logic [CNT_W-1:0] WIN_RST = '1;

  logic en_q, rsten_q, tof_q, warn_q, lock_q, cause_q;
  logic [CNT_W-1:0] reload_q, warnval_q, window_q, cnt;
  logic tick, feed_ok, feed_err, load;
  logic wr_ctrl, wr_reload, wr_feed, wr_warn, wr_window;
  logic timeout_evt, ferr_evt, win_evt, prot_evt, warn_evt, rst_req_d;
  logic [CNT_W-1:0] cnt_dec;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_reload = reg_we_i && (reg_addr_i == A_RELOAD);
  assign wr_feed   = reg_we_i && (reg_addr_i == A_FEED);
  assign wr_warn   = reg_we_i && (reg_addr_i == A_WARN);
  assign wr_window = reg_we_i && (reg_addr_i == A_WINDOW);

  wdt_prescale #(.DIV(DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .clr_i (rst_req_d || load),
    .run_i (en_q),
    .tick_o(tick)
  );

  wdt_feed_seq u_feed (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .clr_i     (rst_req_d),
    .we_i      (reg_we_i),
    .is_feed_i (wr_feed),
    .data_i    (reg_wdata_i[7:0]),
    .feed_ok_o (feed_ok),
    .feed_err_o(feed_err)
  );

  wdt_down_cnt #(.W(CNT_W), .RST_VAL(RLD_MIN)) u_cnt (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .clr_i     (rst_req_d),
    .load_i    (load),
    .load_val_i(reload_q),
    .tick_i    (tick),
    .cnt_o     (cnt)
  );

  assign cnt_dec     = cnt - 1'b1;
  assign timeout_evt = en_q && tick && (cnt == '0);
  assign ferr_evt    = en_q && feed_err;
  assign win_evt     = en_q && rsten_q && feed_ok && (cnt > window_q);
  assign prot_evt    = lock_q && wr_reload && !((cnt < warnval_q) && (cnt < window_q));
  assign warn_evt    = en_q && tick && (cnt != '0) && (cnt_dec == warnval_q);
  assign load        = feed_ok || timeout_evt;
  assign rst_req_d   = (rsten_q && (timeout_evt || ferr_evt)) || win_evt || prot_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {en_q, rsten_q, tof_q, warn_q, lock_q, cause_q} <= '0;
      reload_q  <= RLD_MIN;
      warnval_q <= '0;
      window_q  <= WIN_RST;
      rst_req_o <= 1'b0;
    end else if (rst_req_d) begin
      {en_q, rsten_q, tof_q, warn_q, lock_q} <= '0;
      cause_q   <= 1'b1;
      reload_q  <= RLD_MIN;
      warnval_q <= '0;
      window_q  <= WIN_RST;
      rst_req_o <= 1'b1;
    end else begin
      rst_req_o <= 1'b0;
      if (wr_ctrl) begin
        en_q    <= en_q    | reg_wdata_i[B_EN];
        rsten_q <= rsten_q | reg_wdata_i[B_RSTEN];
        lock_q  <= lock_q  | reg_wdata_i[B_LOCK];
      end
      tof_q  <= (tof_q  && !(wr_ctrl && !reg_wdata_i[B_TOF]))  || timeout_evt || ferr_evt;
      warn_q <= (warn_q && !(wr_ctrl &&  reg_wdata_i[B_WARN])) || warn_evt;
      if (wr_reload) reload_q  <= (reg_wdata_i < RLD_MIN) ? RLD_MIN : reg_wdata_i;
      if (wr_warn)   warnval_q <= reg_wdata_i;
      if (wr_window) window_q  <= reg_wdata_i;
    end
  end

  assign irq_o = warn_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[B_EN]    = en_q;
        reg_rdata_o[B_RSTEN] = rsten_q;
        reg_rdata_o[B_TOF]   = tof_q;
        reg_rdata_o[B_WARN]  = warn_q;
        reg_rdata_o[B_LOCK]  = lock_q;
        reg_rdata_o[B_CAUSE] = cause_q;
      end
      A_RELOAD: reg_rdata_o = reload_q;
      A_COUNT:  reg_rdata_o = cnt;
      A_WARN:   reg_rdata_o = warnval_q;
      A_WINDOW: reg_rdata_o = window_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
  parameter int CNT_W      = 24,
  parameter int MIN_RELOAD = 'hFF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             rsten_q,
  input logic             lock_q,
  input logic             cause_q,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic [CNT_W-1:0] reload_q
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R11
  AST_RST_SETS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cause_q); // R11
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> (en_q || rst_req_o)); // R2
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsten_q || lock_q) |=> ((rsten_q || rst_req_o) && (lock_q || rst_req_o)) || !$past(rsten_q && lock_q)); // R2
  AST_RELOAD_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_q >= CNT_W'(MIN_RELOAD)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_q)); // R4
endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_q     (en_q),
  .rsten_q  (rsten_q),
  .lock_q   (lock_q),
  .cause_q  (cause_q),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o),
  .reload_q (reload_q)
);

// File: tb/sim_wdt_window_top.sv
module sim_wdt_window_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  localparam logic [2:0] CTRL = 3'd0, RELOAD = 3'd1, FEED = 3'd2,
                         COUNT = 3'd3, WARN = 3'd4, WINDOW = 3'd5;

  typedef struct {
    int         kind;   // 0 register read, 1 pins {irq,rst}, 2 pulse count, 3 max pulse width
    logic [2:0] addr;
    int         exp;
    int         mask;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic irq, rst_req;

  item_t q[$];
  logic mon_req = 0;
  int compared = 0, mismatched = 0;
  int pulses = 0, run_len = 0, max_w = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_window_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  // monitor: samples a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && rst_req) begin
      pulses++; run_len++;
      if (run_len > max_w) max_w = run_len;
    end else run_len = 0;
    if (mon_req) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0: act = int'(rdata) & it.mask;
        1: act = {irq, rst_req};
        2: act = pulses;
        default: act = max_w;
      endcase
      compared++;
      if (act != (it.exp & it.mask)) begin
        mismatched++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp & it.mask);
      end
      mon_req = 0;
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); we = 1; addr = a; wdata = W'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic feed();
    wr(FEED, 'hAA); wr(FEED, 'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input int kind, input logic [2:0] a, input int e, input int m, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.mask = m; it.tag = tag;
    q.push_back(it);
    mon_req = 1;
    wait (mon_req == 0);
  endtask

  task automatic exp_reg(input logic [2:0] a, input int e, input int m, input string tag);
    expect_item(0, a, e, m, tag);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset state
    exp_reg(CTRL, 0, 'hFFFFFF, "R1 ctrl");
    exp_reg(RELOAD, 'hFF, 'hFFFFFF, "R1 reload");
    exp_reg(COUNT, 'hFF, 'hFFFFFF, "R1 count");
    exp_reg(WARN, 0, 'hFFFFFF, "R1 warn");
    exp_reg(WINDOW, 'hFFFFFF, 'hFFFFFF, "R1 window");
    expect_item(1, CTRL, 0, 3, "R1 pins");

    // R2 enable set-only (interrupt mode)
    wr(CTRL, 'h1);
    wr(CTRL, 'h0);
    exp_reg(CTRL, 'h1, 'h3, "R2 enable sticky");

    // R5 reload floor
    wr(RELOAD, 'h10);
    exp_reg(RELOAD, 'hFF, 'hFFFFFF, "R5 clamp");
    wr(RELOAD, 'h300);
    exp_reg(RELOAD, 'h300, 'hFFFFFF, "R5 pass");

    // R8 feed reload, R6 divide-by-4 rate
    feed();
    exp_reg(COUNT, 'h300, 'hFFFFFF, "R8 feed loads count");
    idle(40);
    exp_reg(COUNT, 'h2F6, 'hFFFFFF, "R6 count rate");

    // R3 feed error sets flag, write 0 clears
    wr(FEED, 'hAA);
    wr(RELOAD, 'h300);
    exp_reg(CTRL, 'h4, 'h4, "R3 feed error flag");
    expect_item(2, CTRL, 0, -1, "R3 no reset in irq mode");
    wr(CTRL, 'h0);
    exp_reg(CTRL, 'h1, 'h5, "R3 flag cleared");

    // R4 warning
    wr(RELOAD, 'h100);
    wr(WARN, 'hF0);
    feed();
    idle(100);
    expect_item(1, CTRL, 2, 3, "R4 irq high");
    exp_reg(CTRL, 'h8, 'h8, "R4 warn flag");
    wr(CTRL, 'h8);
    expect_item(1, CTRL, 0, 3, "R4 irq cleared");

    // R7 interrupt-mode timeout
    idle(1000);
    exp_reg(CTRL, 'h4, 'h4, "R7 timeout flag");
    expect_item(2, CTRL, 0, -1, "R7 no reset");

    // R11 reset-mode timeout
    wr(CTRL, 'h3);
    idle(1100);
    expect_item(2, CTRL, 1, -1, "R11 one pulse");
    expect_item(3, CTRL, 1, -1, "R11 pulse width");
    exp_reg(CTRL, 'h20, 'hFFFFFF, "R11 ctrl after reset");
    exp_reg(RELOAD, 'hFF, 'hFFFFFF, "R11 reload after reset");
    expect_item(1, CTRL, 0, 3, "R11 pins after reset");

    // R9 window
    wr(WINDOW, 'h80);
    wr(CTRL, 'h3);
    idle(540);
    feed();
    exp_reg(COUNT, 'hFF, 'hFFFFFF, "R9 late feed accepted");
    expect_item(2, CTRL, 1, -1, "R9 no reset for late feed");
    feed();
    expect_item(2, CTRL, 2, -1, "R9 early feed resets");

    // R10 protect
    wr(CTRL, 'h13);
    wr(RELOAD, 'h200);
    expect_item(2, CTRL, 3, -1, "R10 locked write resets");
    exp_reg(RELOAD, 'hFF, 'hFFFFFF, "R10 locked value kept");
    wr(CTRL, 'h13);
    wr(WARN, 'hF0);
    wr(WINDOW, 'hF0);
    idle(80);
    wr(RELOAD, 'h200);
    expect_item(2, CTRL, 3, -1, "R10 allowed write no reset");
    exp_reg(RELOAD, 'h200, 'hFFFFFF, "R10 allowed write stored");
    wr(CTRL, 'h0);
    exp_reg(CTRL, 'h33, 'h33, "R2 mode and lock sticky");
    expect_item(3, CTRL, 1, -1, "R11 all pulses single");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule